// File: doc/BRIEF.md
# EDO DRAM Cycle Type Decoder

This block sits on the device side of a 16-bit extended-data-out DRAM interface and is clocked by a free-running oversampling clock. Every clock it samples the row strobe, the two byte-lane column strobes (upper and lower), the write strobe and the output enable, all active low. It compares each sample against the one before it to find strobe edges, and from those edges it decides what kind of memory cycle the host is running. It latches the row and column addresses at the strobe edges that define them. It emits the per-lane write strobes, a read strobe and the per-lane tri-state drive enables that a storage array and its pad ring need.

The cycle class is chosen from the combined column strobe: the class starts at the first of the two lane strobes to fall and ends once both are high again. Writing and output drive are still decided per byte lane. A refresh pulse is issued at every row strobe fall. It carries the row to refresh: either the latched address, or the value of an internal refresh counter that advances on each column-before-row refresh. Pin inputs are taken as already synchronous to the oversampling clock. Every output is registered and reflects the pin sample taken at the clock edge where it changes.

Top module: `edo_cycle_decoder`

## Requirements
- R1: While the row strobe is sampled high, `cyc_type` reads 0 (standby) after that edge and no `rd_en` or `wr_en` pulse is produced, whatever the other pins do; reset also gives `cyc_type` 0, no drive, and a refresh count of 0.
- R2: A row strobe fall sampled with both column strobes high gives `cyc_type` 4 (row-only refresh). It pulses `ref_pulse` and loads `row_addr` and `ref_row` with `addr`.
- R3: A row strobe fall sampled with either column strobe low, including one falling in the same sample, gives `cyc_type` 5 (column-before-row refresh). It pulses `ref_pulse`, sets `ref_row` to the counter value before the step and adds one to `ref_cnt`. Column and write strobe activity then causes no `rd_en` or `wr_en` until the row strobe rises.
- R4: The first lane strobe to fall while a row is open and not in refresh loads `col_addr` with the low `COL_W` bits of `addr`. A later fall of the other lane in the same access does not reload it.
- R5: If the write strobe is low when the first column strobe falls, `cyc_type` becomes 2 (early write). Each lane pulses its `wr_en` bit (bit 1 upper, bit 0 lower) at its own strobe fall, and `lane_oe` stays 0 for that access.
- R6: If the write strobe is high when the first column strobe falls, `cyc_type` becomes 1 (read) and `rd_en` pulses for one clock.
- R7: A write strobe fall during a read access, with a column strobe low, gives `cyc_type` 3 (delayed write or read-modify-write). It pulses `wr_en` on exactly the lanes whose column strobe is low in that sample.
- R8: A lane's `lane_oe` bit is 1 only if that lane's column strobe fell in the current read access, and only while output enable is low and the write strobe is high.
- R9: Read drive holds after the column strobes rise while the row strobe stays low. It ends at the first sample in which the row strobe and both column strobes are all high.
- R10: The refresh counter is `ROW_W` bits wide and wraps to 0 after its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed row/column address |
| cyc_type | output | 3 | Cycle class: 0 standby, 1 read, 2 early write, 3 delayed write/RMW, 4 row-only refresh, 5 column-before-row refresh |
| row_addr | output | ROW_W | Latched row address |
| col_addr | output | COL_W | Latched column address |
| wr_en | output | 2 | Per-lane write pulse, bit 1 upper |
| rd_en | output | 1 | Read access pulse |
| lane_oe | output | 2 | Per-lane data drive enable, bit 1 upper |
| ref_pulse | output | 1 | One-clock pulse per row strobe fall |
| ref_row | output | ROW_W | Row to refresh for the last pulse |
| ref_cnt | output | ROW_W | Internal refresh counter |

## Verification
The decoder is driven with standby noise on the column, write and enable pins, to show that nothing leaks out while no row is open. It then gets row-only refresh, word and single-byte reads, and page-mode reads with a new column per access, to separate the read class and lane selection from the refresh class. Early writes with staggered lanes are contrasted with delayed writes on one or both lanes, which tells the write-strobe timing apart from the column-strobe timing. Column-before-row refreshes, including a row strobe that falls in the same sample as a column strobe and a run long enough to wrap the counter, test the refresh path and its lock-out of accesses.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;

    localparam int NLANE = 2;

    typedef enum logic [2:0] {
        CYC_IDLE     = 3'd0,
        CYC_READ     = 3'd1,
        CYC_WR_EARLY = 3'd2,
        CYC_WR_LATE  = 3'd3,
        CYC_REF_ROW  = 3'd4,
        CYC_REF_CBR  = 3'd5
    } cyc_e;

    // Sampled strobe pins, all active low; cas_n[1] is the upper lane.
    typedef struct packed {
        logic             ras_n;
        logic [NLANE-1:0] cas_n;
        logic             we_n;
    } pins_t;

    // Edge events found by comparing one sample with the previous one.
    typedef struct packed {
        logic             ras_fall;
        logic             cas_first_fall;
        logic [NLANE-1:0] lane_fall;
        logic             we_fall;
    } edges_t;

    localparam pins_t PINS_IDLE = '{ras_n: 1'b1, cas_n: {NLANE{1'b1}}, we_n: 1'b1};

    function automatic logic any_cas_low(input logic [NLANE-1:0] c);
        return ~&c;
    endfunction

    function automatic logic is_write_class(input cyc_e m);
        return (m == CYC_WR_EARLY) || (m == CYC_WR_LATE);
    endfunction

endpackage

// File: rtl/edo_strobe_edge.sv
module edo_strobe_edge
    import edo_dec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pins_t  pins,
    output edges_t ev
);

    pins_t            prev_q;
    logic [NLANE-1:0] lane_fall_w;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PINS_IDLE;
        else     prev_q <= pins;
    end

    for (genvar i = 0; i < NLANE; i++) begin : g_fall
        assign lane_fall_w[i] = prev_q.cas_n[i] & ~pins.cas_n[i];
    end

    always_comb begin
        ev.ras_fall       = prev_q.ras_n & ~pins.ras_n;
        ev.cas_first_fall = ~any_cas_low(prev_q.cas_n) & any_cas_low(pins.cas_n);
        ev.lane_fall      = lane_fall_w;
        ev.we_fall        = prev_q.we_n & ~pins.we_n;
    end

endmodule

// File: rtl/edo_cycle_class.sv
module edo_cycle_class
    import edo_dec_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  pins_t            pins,
    input  edges_t           ev,
    input  logic [ROW_W-1:0] addr,
    output cyc_e             mode_q,
    output cyc_e             mode_n,
    output logic             late_ev,
    output logic             cycle_end,
    output logic [ROW_W-1:0] row_q,
    output logic [COL_W-1:0] col_q,
    output logic             rd_q,
    output logic             ref_pulse_q,
    output logic [ROW_W-1:0] ref_row_q,
    output logic [ROW_W-1:0] ref_cnt_q
);

    logic cas_low;

    assign cas_low   = any_cas_low(pins.cas_n);
    assign cycle_end = pins.ras_n & ~cas_low;
    assign late_ev   = ev.we_fall & ~pins.ras_n & cas_low
                     & ~ev.cas_first_fall & (mode_q == CYC_READ);

    always_comb begin
        mode_n = mode_q;
        if (pins.ras_n)
            mode_n = CYC_IDLE;
        else if (ev.ras_fall)
            mode_n = cas_low ? CYC_REF_CBR : CYC_REF_ROW;
        else if (mode_q == CYC_REF_CBR)
            mode_n = CYC_REF_CBR;
        else if (ev.cas_first_fall)
            mode_n = pins.we_n ? CYC_READ : CYC_WR_EARLY;
        else if (late_ev)
            mode_n = CYC_WR_LATE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= CYC_IDLE;
            row_q       <= '0;
            col_q       <= '0;
            rd_q        <= 1'b0;
            ref_pulse_q <= 1'b0;
            ref_row_q   <= '0;
            ref_cnt_q   <= '0;
        end else begin
            mode_q      <= mode_n;
            rd_q        <= ev.cas_first_fall & (mode_n == CYC_READ);
            ref_pulse_q <= ev.ras_fall;
            if (ev.ras_fall && mode_n == CYC_REF_ROW) begin
                row_q     <= addr;
                ref_row_q <= addr;
            end
            if (ev.ras_fall && mode_n == CYC_REF_CBR) begin
                ref_row_q <= ref_cnt_q;
                ref_cnt_q <= ref_cnt_q + 1'b1;
            end
            if (ev.cas_first_fall && (mode_n == CYC_READ || mode_n == CYC_WR_EARLY))
                col_q <= addr[COL_W-1:0];
        end
    end

endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl
    import edo_dec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lane_fall,
    input  logic cas_low,
    input  logic cas_first_fall,
    input  logic cycle_end,
    input  cyc_e mode_n,
    input  logic late_ev,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_q,
    output logic oe_q
);

    logic armed_q;
    logic armed_n;

    // A lane holds read data from its own strobe fall in a read access
    // until a new access starts or the whole cycle has closed.
    always_comb begin
        armed_n = armed_q;
        if (cycle_end)
            armed_n = 1'b0;
        else if (lane_fall && mode_n == CYC_READ)
            armed_n = 1'b1;
        else if (cas_first_fall)
            armed_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            wr_q    <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            armed_q <= armed_n;
            wr_q    <= (lane_fall & ~we_n & is_write_class(mode_n)) | (late_ev & cas_low);
            oe_q    <= armed_n & ~oe_n & we_n;
        end
    end

endmodule

// File: rtl/edo_cycle_decoder.sv
module edo_cycle_decoder
    import edo_dec_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic             ucas_n,
    input  logic             lcas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    output logic [2:0]       cyc_type,
    output logic [ROW_W-1:0] row_addr,
    output logic [COL_W-1:0] col_addr,
    output logic [1:0]       wr_en,
    output logic             rd_en,
    output logic [1:0]       lane_oe,
    output logic             ref_pulse,
    output logic [ROW_W-1:0] ref_row,
    output logic [ROW_W-1:0] ref_cnt
);

    pins_t  pins;
    edges_t ev;
    cyc_e   mode_q;
    cyc_e   mode_n;
    logic   late_ev;
    logic   cycle_end;

    always_comb begin
        pins.ras_n = ras_n;
        pins.cas_n = {ucas_n, lcas_n};
        pins.we_n  = we_n;
    end

    edo_strobe_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pins (pins),
        .ev   (ev)
    );

    edo_cycle_class #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_class (
        .clk         (clk),
        .rst         (rst),
        .pins        (pins),
        .ev          (ev),
        .addr        (addr),
        .mode_q      (mode_q),
        .mode_n      (mode_n),
        .late_ev     (late_ev),
        .cycle_end   (cycle_end),
        .row_q       (row_addr),
        .col_q       (col_addr),
        .rd_q        (rd_en),
        .ref_pulse_q (ref_pulse),
        .ref_row_q   (ref_row),
        .ref_cnt_q   (ref_cnt)
    );

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        edo_lane_ctrl u_lane (
            .clk            (clk),
            .rst            (rst),
            .lane_fall      (ev.lane_fall[i]),
            .cas_low        (~pins.cas_n[i]),
            .cas_first_fall (ev.cas_first_fall),
            .cycle_end      (cycle_end),
            .mode_n         (mode_n),
            .late_ev        (late_ev),
            .we_n           (we_n),
            .oe_n           (oe_n),
            .wr_q           (wr_en[i]),
            .oe_q           (lane_oe[i])
        );
    end

    assign cyc_type = mode_q;

endmodule

// File: rtl/edo_cycle_decoder_chk.sv
module edo_cycle_decoder_chk #(
    parameter int ROW_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             ras_n,
    input logic             we_n,
    input logic             oe_n,
    input logic [2:0]       cyc_type,
    input logic [1:0]       wr_en,
    input logic             rd_en,
    input logic [1:0]       lane_oe,
    input logic             ref_pulse,
    input logic [ROW_W-1:0] ref_cnt
);

    p_standby_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        ras_n |=> (cyc_type == 3'd0 && !rd_en && wr_en == 2'b00));

    p_pulse_class_r2: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> (cyc_type == 3'd4 || cyc_type == 3'd5));

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        (ref_pulse && cyc_type == 3'd5) |-> (ref_cnt == ROW_W'($past(ref_cnt) + 1'b1)));

    p_early_no_drive_r5: assert property (@(posedge clk) disable iff (rst)
        (cyc_type == 3'd2) |-> (lane_oe == 2'b00));

    p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en != 2'b00));

    p_late_writes_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc_type == 3'd3 && $past(cyc_type) == 3'd1) |-> (wr_en != 2'b00));

    p_drive_gated_r8: assert property (@(posedge clk) disable iff (rst)
        (lane_oe != 2'b00) |-> (!$past(oe_n) && $past(we_n)));

endmodule

bind edo_cycle_decoder edo_cycle_decoder_chk #(.ROW_W(ROW_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .cyc_type  (cyc_type),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .lane_oe   (lane_oe),
    .ref_pulse (ref_pulse),
    .ref_cnt   (ref_cnt)
);

// File: tb/test_edo_cycle_decoder.sv
module test_edo_cycle_decoder;

    localparam int ROW_W = 12;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ROW_W-1:0] addr = '0;
    logic [2:0]       cyc_type;
    logic [ROW_W-1:0] row_addr;
    logic [COL_W-1:0] col_addr;
    logic [1:0]       wr_en;
    logic             rd_en;
    logic [1:0]       lane_oe;
    logic             ref_pulse;
    logic [ROW_W-1:0] ref_row;
    logic [ROW_W-1:0] ref_cnt;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    edo_cycle_decoder #(.ROW_W(ROW_W), .COL_W(COL_W)) i_edo_cycle_decoder (
        .clk(clk), .rst(rst), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .cyc_type(cyc_type),
        .row_addr(row_addr), .col_addr(col_addr), .wr_en(wr_en), .rd_en(rd_en),
        .lane_oe(lane_oe), .ref_pulse(ref_pulse), .ref_row(ref_row), .ref_cnt(ref_cnt)
    );

    // Reference model state: previous pins and expected outputs.
    bit       mp_ras = 1, mp_we = 1;
    bit [1:0] mp_cas = 2'b11;
    int       m_mode = 0, m_row = 0, m_col = 0, m_cnt = 0, m_refrow = 0;
    bit [1:0] m_armed = 0, e_wr = 0, e_oe = 0;
    bit       e_rd = 0, e_pulse = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            1: return "R6";
            2: return "R5";
            3: return "R7";
            4: return "R2";
            5: return "R3";
            default: return "R1";
        endcase
    endfunction

    // Advance the model by one sample of the pins.
    task automatic model_step();
        bit [1:0] c = {ucas_n, lcas_n};
        bit now_low = (c != 2'b11);
        bit was_low = (mp_cas != 2'b11);
        bit first_fall = now_low && !was_low;
        int nm;
        e_wr = 0; e_rd = 0; e_pulse = 0;
        if (ras_n) nm = 0;
        else if (mp_ras) begin
            e_pulse = 1;
            if (now_low) begin
                nm = 5; m_refrow = m_cnt; m_cnt = (m_cnt + 1) % (1 << ROW_W);
            end else begin
                nm = 4; m_row = addr; m_refrow = addr;
            end
        end else if (m_mode == 5) nm = 5;
        else if (first_fall) begin
            nm = we_n ? 1 : 2;
            m_col = addr % (1 << COL_W);
            e_rd = we_n;
        end else if (mp_we && !we_n && m_mode == 1 && now_low) nm = 3;
        else nm = m_mode;
        for (int i = 0; i < 2; i++) begin
            bit fell = mp_cas[i] && !c[i];
            if (fell && !we_n && (nm == 2 || nm == 3)) e_wr[i] = 1;
            if (nm == 3 && m_mode == 1 && !c[i]) e_wr[i] = 1;
            if (ras_n && !now_low) m_armed[i] = 0;
            else if (fell && nm == 1) m_armed[i] = 1;
            else if (first_fall) m_armed[i] = 0;
            e_oe[i] = m_armed[i] && !oe_n && we_n;
        end
        m_mode = nm;
        mp_ras = ras_n; mp_cas = c; mp_we = we_n;
    endtask

    task automatic compare_all();
        string rtag = (m_mode == 5) ? "R3" : "R2";
        chk(mode_tag(m_mode), "cyc_type", int'(cyc_type), m_mode);
        chk("R2", "row_addr", int'(row_addr), m_row);
        chk("R4", "col_addr", int'(col_addr), m_col);
        chk((m_mode == 2) ? "R5" : "R7", "wr_en", int'(wr_en), int'(e_wr));
        chk("R6", "rd_en", int'(rd_en), int'(e_rd));
        chk("R8", "lane_oe", int'(lane_oe), int'(e_oe));
        chk(rtag, "ref_pulse", int'(ref_pulse), int'(e_pulse));
        chk(rtag, "ref_row", int'(ref_row), m_refrow);
        chk("R3", "ref_cnt", int'(ref_cnt), m_cnt);
    endtask

    // Drive one sample (ras, ucas, lcas, we, oe, addr) for one clock.
    task automatic apply(input bit r, input bit u, input bit l, input bit w, input bit o, input int a);
        ras_n = r; ucas_n = u; lcas_n = l; we_n = w; oe_n = o; addr = ROW_W'(a);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic cbr_once();
        apply(1, 0, 0, 1, 1, 0);
        apply(0, 0, 0, 1, 1, 0);
        apply(1, 0, 0, 1, 1, 0);
        apply(1, 1, 1, 1, 1, 0);
    endtask

    initial begin
        int cnt_before;
        repeat (3) @(negedge clk);
        chk("R1", "reset cyc_type", int'(cyc_type), 0);
        chk("R1", "reset lane_oe", int'(lane_oe), 0);
        chk("R1", "reset ref_cnt", int'(ref_cnt), 0);
        rst = 1'b0;

        // R1: standby with noise on the other pins
        apply(1, 0, 1, 0, 0, 12'h111);
        apply(1, 0, 0, 1, 0, 12'h222);
        apply(1, 1, 0, 0, 1, 12'h333);
        chk("R1", "standby wr_en", int'(wr_en), 0);
        apply(1, 1, 1, 1, 1, 0);

        // R2: row-only refresh
        apply(0, 1, 1, 1, 1, 12'hABC);
        chk("R2", "row latched", int'(row_addr), 12'hABC);
        chk("R2", "refresh row", int'(ref_row), 12'hABC);
        apply(0, 1, 1, 1, 1, 0);
        apply(1, 1, 1, 1, 1, 0);

        // R6/R8/R9: word read with EDO hold
        apply(0, 1, 1, 1, 0, 12'h123);
        apply(0, 0, 0, 1, 0, 12'h045);
        chk("R6", "read pulse", int'(rd_en), 1);
        apply(0, 0, 0, 1, 0, 0);
        chk("R8", "word drive", int'(lane_oe), 3);
        apply(0, 1, 1, 1, 0, 0);
        apply(0, 1, 1, 1, 0, 0);
        chk("R9", "hold after cas rise", int'(lane_oe), 3);
        apply(1, 1, 1, 1, 0, 0);
        chk("R9", "drive ends", int'(lane_oe), 0);

        // R8: upper byte only; OE high turns drive off; page mode R4
        apply(0, 1, 1, 1, 0, 12'h200);
        apply(0, 0, 1, 1, 0, 12'h0F1);
        apply(0, 0, 1, 1, 0, 0);
        chk("R8", "upper only", int'(lane_oe), 2);
        apply(0, 0, 1, 1, 1, 0);
        chk("R8", "oe high", int'(lane_oe), 0);
        apply(0, 1, 1, 1, 0, 0);
        apply(0, 1, 0, 1, 0, 12'h0F2);
        apply(0, 0, 0, 1, 0, 12'h0F3);
        chk("R4", "page column kept", int'(col_addr), 8'hF2);
        apply(0, 1, 1, 1, 0, 0);
        apply(1, 1, 1, 1, 1, 0);
        apply(1, 1, 1, 1, 1, 0);

        // R5: early write, staggered lanes, WE rises later
        apply(0, 1, 1, 0, 0, 12'h300);
        apply(0, 1, 0, 0, 0, 12'h031);
        chk("R5", "lower write", int'(wr_en), 1);
        apply(0, 0, 0, 0, 0, 0);
        chk("R5", "upper write", int'(wr_en), 2);
        apply(0, 0, 0, 1, 0, 0);
        chk("R5", "no drive", int'(lane_oe), 0);
        apply(1, 1, 1, 1, 1, 0);

        // R7: delayed write on both lanes, then RMW on lower only
        apply(0, 1, 1, 1, 1, 12'h400);
        apply(0, 0, 0, 1, 1, 12'h041);
        apply(0, 0, 0, 0, 1, 0);
        chk("R7", "late both", int'(wr_en), 3);
        apply(0, 1, 1, 1, 1, 0);
        apply(0, 1, 0, 1, 0, 12'h042);
        apply(0, 1, 0, 1, 0, 0);
        apply(0, 1, 0, 0, 1, 0);
        chk("R7", "late lower", int'(wr_en), 1);
        chk("R7", "late class", int'(cyc_type), 3);
        apply(1, 1, 1, 1, 1, 0);

        // R3: CBR, then access attempts ignored
        apply(1, 0, 1, 1, 1, 0);
        apply(0, 0, 1, 1, 1, 0);
        chk("R3", "cbr class", int'(cyc_type), 5);
        chk("R3", "cbr row", int'(ref_row), 0);
        apply(0, 1, 1, 1, 0, 0);
        apply(0, 0, 0, 1, 0, 0);
        chk("R3", "no read in cbr", int'(rd_en), 0);
        apply(0, 0, 0, 0, 0, 0);
        chk("R3", "no write in cbr", int'(wr_en), 0);
        apply(1, 1, 1, 1, 1, 0);
        // R3: RAS and CAS fall in the same sample
        apply(0, 0, 0, 1, 1, 0);
        chk("R3", "same-sample cbr", int'(cyc_type), 5);
        apply(1, 1, 1, 1, 1, 0);

        // R10: full wrap of the refresh counter
        cnt_before = int'(ref_cnt);
        for (int k = 0; k < (1 << ROW_W); k++) cbr_once();
        chk("R10", "counter wrapped", int'(ref_cnt), cnt_before);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule